// File: doc/BRIEF.md
# ACPI Power Management Event Core

This block holds the fixed-function power-management registers of a chipset: a free-running timer, an event status word, an event enable word and a control word. Software reaches them through a small word-wide register bus. The block raises a level interrupt while any enabled event is pending. It also turns a few software actions into one-cycle request pulses for the surrounding system logic: soft power-off, reset-with-resume and a system-management interrupt.

The timer advances on a tick enable that runs at the power-management timer rate. Event sources are a power-button press, a timer overflow, and two external event strobes (global and real-time clock). A byte-wide command port, in the style of an APM command register, can switch the interrupt-enable control bit on or off from firmware. It can also request a system-management interrupt.

Top module: `pm_event_core`

## Requirements
- R1: After reset, the status, enable, control and timer registers all read 0, and the outputs `sci`, `off_req`, `rst_req` and `smi_req` are low.
- R2: The timer is `TMR_W` bits wide (24 by default). It increments by one on each clock where `tick_en` is high and wraps modulo 2^TMR_W. Address 3 reads it zero-extended to 32 bits, and writes to address 3 are ignored.
- R3: Status bit 0 (timer overflow) is set on each tick that changes the timer's top bit, that is, once every 2^(TMR_W-1) ticks.
- R4: Status (address 0) is write-one-to-clear. A set event in the same cycle as a clear of that bit wins. Only bits 0, 5, 8, 10 and 15 exist; the other bits read 0.
- R5: `gbl_evt` sets status bit 5 and `rtc_evt` sets status bit 10, whatever the enables are. `pwrbtn_press` sets status bit 8 only while enable bit 8 is 1. Enable (address 1) stores only bits 0, 5, 8 and 10.
- R6: `sci` is high exactly while (status AND enable) has any of bits 0, 5, 8 or 10 set.
- R7: Control (address 2) stores every written bit except bit 13, which always reads 0.
- R8: A control write with bit 13 = 1 and bits 12:10 = 0 raises `off_req` for exactly one cycle after the write.
- R9: A control write with bit 13 = 1 and bits 12:10 = 1 sets status bits 15 and 8 and raises `rst_req` for one cycle. Bit 13 with any other suspend type raises neither pulse.
- R10: An APM port write of 0xF1 sets control bit 0, a write of 0xF0 clears it, and other values leave it unchanged. The APM write decides bit 0 when it coincides with a bus control write.
- R11: Each APM port write raises `smi_req` for one cycle if `smi_cfg_en` is high, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-rate tick enable |
| bus_addr | input | 2 | Register select: 0 status, 1 enable, 2 control, 3 timer |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwrbtn_press | input | 1 | Power-button press strobe |
| gbl_evt | input | 1 | Global event strobe |
| rtc_evt | input | 1 | Real-time-clock event strobe |
| apm_wr | input | 1 | APM command port write strobe |
| apm_data | input | 8 | APM command byte |
| smi_cfg_en | input | 1 | Configuration bit enabling SMI on APM writes |
| sci | output | 1 | Level interrupt |
| off_req | output | 1 | Soft power-off request pulse |
| rst_req | output | 1 | Reset request pulse |
| smi_req | output | 1 | System-management interrupt pulse |

## Verification
The hardest case to reach from the ports is a timer overflow that lands in the same cycle as software clearing the overflow bit. To get there, the bench keeps its own copy of the timer and ticks until that copy is one tick below the top-bit change. It then issues the write-one-to-clear on that exact tick. The bench uses a narrow timer so that both the overflow and the full wrap are reached quickly. Random stretches then mix writes, events and APM commands against a bench model of every register.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    A_STS  = 2'd0,
    A_EN   = 2'd1,
    A_CTRL = 2'd2,
    A_TMR  = 2'd3
  } pm_addr_e;

  localparam int REG_W   = 16;
  localparam int RD_W    = 32;
  localparam int B_TMR   = 0;
  localparam int B_GBL   = 5;
  localparam int B_PWR   = 8;
  localparam int B_RTC   = 10;
  localparam int B_RSM   = 15;
  localparam int B_SCIEN = 0;
  localparam int B_SUSEN = 13;
  localparam int SUS_LO  = 10;

  localparam logic [REG_W-1:0] SCI_MASK = (REG_W'(1) << B_TMR) | (REG_W'(1) << B_GBL) |
                                          (REG_W'(1) << B_PWR) | (REG_W'(1) << B_RTC);
  localparam logic [REG_W-1:0] STS_MASK = SCI_MASK | (REG_W'(1) << B_RSM);
  localparam logic [REG_W-1:0] EN_MASK  = SCI_MASK;
  localparam logic [REG_W-1:0] CTRL_MASK = ~(REG_W'(1) << B_SUSEN);

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;
  localparam logic [2:0] SUS_SOFTOFF = 3'd0;
  localparam logic [2:0] SUS_RESUME  = 3'd1;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] cnt_q,
  output logic             ovf_evt
);
  localparam int LOW_W = TMR_W - 1;

  logic [TMR_W-1:0] cnt_d;

  // The top bit flips exactly when all lower bits are one and a tick arrives.
  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    ovf_evt = tick_en & (&cnt_q[LOW_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             apm_wr,
  input  logic [7:0]       apm_data,
  input  logic             smi_cfg_en,
  output logic [REG_W-1:0] ctrl_q,
  output logic             off_req,
  output logic             rst_req,
  output logic             smi_req,
  output logic             resume_evt
);
  logic [REG_W-1:0] ctrl_d;
  logic             ctrl_ce;
  logic [2:0]       sus_typ;
  logic             sus_go;
  logic             off_d;
  logic             smi_d;

  always_comb begin
    sus_typ    = wdata[SUS_LO +: 3];
    sus_go     = wr_ctrl & wdata[B_SUSEN];
    off_d      = sus_go & (sus_typ == SUS_SOFTOFF);
    resume_evt = sus_go & (sus_typ == SUS_RESUME);
    smi_d      = apm_wr & smi_cfg_en;
    ctrl_ce    = wr_ctrl | apm_wr;
    ctrl_d     = ctrl_q;
    if (wr_ctrl) ctrl_d = wdata & CTRL_MASK;
    if (apm_wr) begin
      if (apm_data == APM_SCI_ON)       ctrl_d[B_SCIEN] = 1'b1;
      else if (apm_data == APM_SCI_OFF) ctrl_d[B_SCIEN] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_req <= 1'b0;
      rst_req <= 1'b0;
      smi_req <= 1'b0;
    end else begin
      off_req <= off_d;
      rst_req <= resume_evt;
      smi_req <= smi_d;
    end
  end
endmodule

// File: rtl/pm_events.sv
module pm_events
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ovf_evt,
  input  logic             gbl_evt,
  input  logic             rtc_evt,
  input  logic             pwrbtn,
  input  logic             resume_evt,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic             sci
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] sts_d;

  always_comb begin
    set_vec        = '0;
    set_vec[B_TMR] = ovf_evt;
    set_vec[B_GBL] = gbl_evt;
    set_vec[B_PWR] = (pwrbtn & en_q[B_PWR]) | resume_evt;
    set_vec[B_RTC] = rtc_evt;
    set_vec[B_RSM] = resume_evt;
    clr_vec        = sts_wr ? wdata : '0;
    // Setting has priority over a coincident write-one-to-clear.
    sts_d          = (set_vec | (sts_q & ~clr_vec)) & STS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata & EN_MASK;
  end

  assign sci = |(sts_q & en_q & SCI_MASK);
endmodule

// File: rtl/pm_event_core.sv
module pm_event_core
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [15:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            pwrbtn_press,
  input  logic            gbl_evt,
  input  logic            rtc_evt,
  input  logic            apm_wr,
  input  logic [7:0]      apm_data,
  input  logic            smi_cfg_en,
  output logic            sci,
  output logic            off_req,
  output logic            rst_req,
  output logic            smi_req
);
  localparam int PAD_W = RD_W - TMR_W;

  logic             rst_sync_n;
  logic [TMR_W-1:0] tmr_q;
  logic             ovf_evt;
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] ctrl_q;
  logic             resume_evt;
  logic             sts_wr;
  logic             en_wr;
  logic             ctrl_wr;

  always_comb begin
    sts_wr  = bus_wr & (bus_addr == A_STS);
    en_wr   = bus_wr & (bus_addr == A_EN);
    ctrl_wr = bus_wr & (bus_addr == A_CTRL);
  end

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .cnt_q   (tmr_q),
    .ovf_evt (ovf_evt)
  );

  pm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl    (ctrl_wr),
    .wdata      (bus_wdata),
    .apm_wr     (apm_wr),
    .apm_data   (apm_data),
    .smi_cfg_en (smi_cfg_en),
    .ctrl_q     (ctrl_q),
    .off_req    (off_req),
    .rst_req    (rst_req),
    .smi_req    (smi_req),
    .resume_evt (resume_evt)
  );

  pm_events u_evt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sts_wr     (sts_wr),
    .en_wr      (en_wr),
    .wdata      (bus_wdata),
    .ovf_evt    (ovf_evt),
    .gbl_evt    (gbl_evt),
    .rtc_evt    (rtc_evt),
    .pwrbtn     (pwrbtn_press),
    .resume_evt (resume_evt),
    .sts_q      (sts_q),
    .en_q       (en_q),
    .sci        (sci)
  );

  always_comb begin
    unique case (bus_addr)
      A_STS:   bus_rdata = {{(RD_W-REG_W){1'b0}}, sts_q};
      A_EN:    bus_rdata = {{(RD_W-REG_W){1'b0}}, en_q};
      A_CTRL:  bus_rdata = {{(RD_W-REG_W){1'b0}}, ctrl_q};
      default: bus_rdata = {{PAD_W{1'b0}}, tmr_q};
    endcase
  end
endmodule

// File: rtl/pm_event_core_chk.sv
module pm_event_core_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [TMR_W-1:0] tmr,
  input logic [15:0]      sts,
  input logic [15:0]      en,
  input logic [15:0]      ctrl,
  input logic             pwrbtn,
  input logic             bus_wr,
  input logic             apm_wr,
  input logic [7:0]       apm_data,
  input logic             smi_cfg_en,
  input logic             off_req,
  input logic             rst_req,
  input logic             smi_req
);
  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick_en)) |-> (tmr == TMR_W'($past(tmr) + 1'b1)));

  p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick_en)) |-> $stable(tmr));

  p_ovf_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick_en) && (&$past(tmr[TMR_W-2:0]))) |-> sts[0]);

  p_pwr_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pwrbtn) && !$past(en[8]) && !$past(sts[8]) && !$past(bus_wr))
      |-> !sts[8]);

  p_off_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |=> !off_req);

  p_rst_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (sts[15] && sts[8]));

  p_apm_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(apm_wr) && ($past(apm_data) == 8'hF1)) |-> ctrl[0]);

  p_smi_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> ($past(apm_wr) && $past(smi_cfg_en)));
endmodule

bind pm_event_core pm_event_core_chk #(.TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick_en    (tick_en),
  .tmr        (tmr_q),
  .sts        (sts_q),
  .en         (en_q),
  .ctrl       (ctrl_q),
  .pwrbtn     (pwrbtn_press),
  .bus_wr     (bus_wr),
  .apm_wr     (apm_wr),
  .apm_data   (apm_data),
  .smi_cfg_en (smi_cfg_en),
  .off_req    (off_req),
  .rst_req    (rst_req),
  .smi_req    (smi_req)
);

// File: tb/tb_pm_event_core.sv
module tb_pm_event_core;
  localparam int TW = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [1:0]  addr;
  logic        wr;
  logic [15:0] wdata;
  logic [31:0] rdata;
  logic        pwr, gbl, rtc, apm_wr, smi_cfg;
  logic [7:0]  apm_data;
  logic        sci, off_req, rst_req, smi_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [TW-1:0] m_tmr;
  logic [15:0]   m_sts, m_en, m_ctrl;
  logic          m_off, m_rst, m_smi;

  always #4 clk = ~clk;

  pm_event_core #(.TMR_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwrbtn_press(pwr), .gbl_evt(gbl),
    .rtc_evt(rtc), .apm_wr(apm_wr), .apm_data(apm_data), .smi_cfg_en(smi_cfg),
    .sci(sci), .off_req(off_req), .rst_req(rst_req), .smi_req(smi_req)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return {16'h0, m_sts};
      2'd1:    return {16'h0, m_en};
      2'd2:    return {16'h0, m_ctrl};
      default: return {{(32-TW){1'b0}}, m_tmr};
    endcase
  endfunction

  function automatic string read_req(logic [1:0] a);
    case (a)
      2'd0:    return "R4";
      2'd1:    return "R5";
      2'd2:    return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic idle();
    tick = 0; addr = 0; wr = 0; wdata = 0; pwr = 0; gbl = 0; rtc = 0;
    apm_wr = 0; apm_data = 0;
  endtask

  task automatic model_step();
    logic        ovf = tick && (&m_tmr[TW-2:0]);
    logic        go  = wr && (addr == 2'd2) && wdata[13];
    logic [2:0]  ty  = wdata[12:10];
    logic [15:0] setv = 16'h0;
    logic [15:0] clrv = (wr && addr == 2'd0) ? wdata : 16'h0;
    setv[0]  = ovf;
    setv[5]  = gbl;
    setv[10] = rtc;
    setv[8]  = (pwr && m_en[8]) || (go && ty == 3'd1);
    setv[15] = go && ty == 3'd1;
    m_sts = (setv | (m_sts & ~clrv)) & 16'h8521;
    if (wr && addr == 2'd1) m_en = wdata & 16'h0521;
    if (wr && addr == 2'd2) m_ctrl = wdata & 16'hDFFF;
    if (apm_wr) begin
      if (apm_data == 8'hF1)      m_ctrl[0] = 1'b1;
      else if (apm_data == 8'hF0) m_ctrl[0] = 1'b0;
    end
    if (tick) m_tmr = m_tmr + 1'b1;
    m_off = go && ty == 3'd0;
    m_rst = go && ty == 3'd1;
    m_smi = apm_wr && smi_cfg;
  endtask

  // One clock with the currently driven inputs, then compare every output.
  task automatic cyc();
    logic exp_sci;
    @(posedge clk);
    model_step();
    @(negedge clk);
    exp_sci = |(m_sts & m_en & 16'h0521);
    chk(sci == exp_sci, "R6 sci", {31'h0, sci}, {31'h0, exp_sci});
    chk(off_req == m_off, "R8 off_req", {31'h0, off_req}, {31'h0, m_off});
    chk(rst_req == m_rst, "R9 rst_req", {31'h0, rst_req}, {31'h0, m_rst});
    chk(smi_req == m_smi, "R11 smi_req", {31'h0, smi_req}, {31'h0, m_smi});
    chk(rdata == exp_read(addr), read_req(addr), rdata, exp_read(addr));
    idle();
  endtask

  task automatic peek(logic [1:0] a, string req, logic [31:0] exp);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
    addr = 2'd0;
  endtask

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    addr = a; wr = 1'b1; wdata = d;
    cyc();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    smi_cfg = 0;
    m_tmr = '0; m_sts = '0; m_en = '0; m_ctrl = '0;
    m_off = 0; m_rst = 0; m_smi = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: everything cleared
    peek(2'd0, "R1 status", 32'h0);
    peek(2'd1, "R1 enable", 32'h0);
    peek(2'd2, "R1 control", 32'h0);
    peek(2'd3, "R1 timer", 32'h0);
    chk({sci, off_req, rst_req, smi_req} == 4'b0, "R1 outputs",
        {28'h0, sci, off_req, rst_req, smi_req}, 32'h0);

    // R5: enable keeps only its implemented bits; gated power button
    bus_write(2'd1, 16'hFFFF);
    peek(2'd1, "R5 enable mask", 32'h0521);
    pwr = 1; cyc();
    peek(2'd0, "R5 pwrbtn enabled", 32'h0100);
    chk(sci == 1'b1, "R6 pwrbtn sci", {31'h0, sci}, 32'h1);
    bus_write(2'd0, 16'h0100);
    peek(2'd0, "R4 w1c", 32'h0);
    bus_write(2'd1, 16'h0000);
    pwr = 1; cyc();
    peek(2'd0, "R5 pwrbtn gated", 32'h0);

    // R5/R6: strobes set status regardless of enables; sci follows enable
    rtc = 1; gbl = 1; cyc();
    peek(2'd0, "R5 rtc gbl", 32'h0420);
    chk(sci == 1'b0, "R6 masked", {31'h0, sci}, 32'h0);
    bus_write(2'd1, 16'h0400);
    chk(sci == 1'b1, "R6 rtc enabled", {31'h0, sci}, 32'h1);
    bus_write(2'd0, 16'hFFFF);
    peek(2'd0, "R4 clear all", 32'h0);

    // R7/R8/R9: control storage and suspend actions
    bus_write(2'd2, 16'hFFFF);
    chk({off_req, rst_req} == 2'b00, "R9 type7 no pulse", {30'h0, off_req, rst_req}, 32'h0);
    peek(2'd2, "R7 bit13 zero", 32'hDFFF);
    bus_write(2'd2, 16'h2000);
    chk(off_req == 1'b1, "R8 off pulse", {31'h0, off_req}, 32'h1);
    cyc();
    chk(off_req == 1'b0, "R8 off one cycle", {31'h0, off_req}, 32'h0);
    peek(2'd2, "R7 readback", 32'h0);
    bus_write(2'd2, 16'h2400);
    chk(rst_req == 1'b1, "R9 rst pulse", {31'h0, rst_req}, 32'h1);
    peek(2'd0, "R9 resume status", 32'h8100);
    bus_write(2'd0, 16'h8100);

    // R10/R11: APM port
    apm_wr = 1; apm_data = 8'hF1; cyc();
    peek(2'd2, "R10 apm on", 32'h0401);
    chk(smi_req == 1'b0, "R11 no cfg", {31'h0, smi_req}, 32'h0);
    smi_cfg = 1;
    apm_wr = 1; apm_data = 8'h55; cyc();
    chk(smi_req == 1'b1, "R11 smi", {31'h0, smi_req}, 32'h1);
    peek(2'd2, "R10 other value", 32'h0401);
    apm_wr = 1; apm_data = 8'hF0; cyc();
    peek(2'd2, "R10 apm off", 32'h0400);
    smi_cfg = 0;
    addr = 2'd2; wr = 1; wdata = 16'h0000; apm_wr = 1; apm_data = 8'hF1; cyc();
    peek(2'd2, "R10 apm beats bus", 32'h0001);

    // R2: timer counts ticks, ignores writes
    repeat (5) begin tick = 1; cyc(); end
    peek(2'd3, "R2 five ticks", 32'h5);
    bus_write(2'd3, 16'hFFFF);
    peek(2'd3, "R2 write ignored", 32'h5);

    // R3/R4: overflow coinciding with a clear of bit 0
    while (m_tmr[TW-2:0] != '1) begin tick = 1; cyc(); end
    tick = 1; addr = 2'd0; wr = 1; wdata = 16'h0001; cyc();
    peek(2'd0, "R3 set beats clear", 32'h0001);
    bus_write(2'd0, 16'h0001);
    peek(2'd0, "R4 ovf cleared", 32'h0);
    while (m_tmr != '1) begin tick = 1; cyc(); end
    tick = 1; cyc();
    peek(2'd3, "R2 wrap", 32'h0);
    peek(2'd0, "R3 ovf at wrap", 32'h0001);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom % 10) != 0;
      wr = ($urandom % 8) == 0;
      addr = 2'($urandom % 4);
      wdata = 16'($urandom);
      pwr = ($urandom % 16) == 0;
      rtc = ($urandom % 32) == 0;
      gbl = ($urandom % 32) == 0;
      apm_wr = ($urandom % 16) == 0;
      case ($urandom % 3)
        0: apm_data = 8'hF0;
        1: apm_data = 8'hF1;
        default: apm_data = 8'($urandom);
      endcase
      smi_cfg = 1'($urandom);
      cyc();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule